// File: doc/BRIEF.md
# Register Auto-Modify Recorder

This block keeps a per-instruction log of the general-register adjustments that addressing modes and implied stack operations make while one instruction executes. After a memory-management abort, recovery software reads the log and subtracts each recorded change from its register. This rolls a partially executed instruction back to its starting register state, so the instruction can be restarted.

The address-mode sequencer reports each adjustment as an event, made of a 3-bit register number and a signed 5-bit change. Up to two events can arrive in one cycle on two lanes, and lane 0 counts as the earlier of the two. The block packs the first two events of an instruction into a 16-bit word and ignores any later ones. A start-of-instruction strobe clears the word. While the abort status is held, the word is frozen, so software sees the state at the moment of the fault.

Top module: `rmr_recorder`

## Requirements
- R1: After reset, `rec_word` reads 0x0000.
- R2: Each 8-bit entry holds the change in bits 7:3 as a two's-complement number and the register number in bits 2:0. Examples: +2 on register 6 is 0x16, -2 on register 6 is 0xF6, +15 on register 7 is 0x7F, and -16 on register 0 is 0x80.
- R3: The first event of an instruction lands in bits 7:0 and the second in bits 15:8. While only one event has been recorded, bits 15:8 read zero.
- R4: When both lanes are valid in one cycle, lane 0 is recorded before lane 1. A lone valid lane 1 takes the next free entry, as lane 0 would.
- R5: Once two events are recorded, further events before the next instruction start leave `rec_word` unchanged. If only one entry is free, only the earlier valid lane is kept.
- R6: `instr_start` with `abort_held` low clears the word. Events in the same cycle as the strobe are recorded into the cleared word, starting at bits 7:0.
- R7: While `abort_held` is high, neither events nor `instr_start` change `rec_word`.
- R8: After `abort_held` falls, the word keeps its frozen value until the next `instr_start`, which clears it. Recording then resumes.
- R9: An event or clear accepted at a clock edge is visible on `rec_word` after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_start | input | 1 | Start of a new instruction; clears the log unless frozen |
| abort_held | input | 1 | Abort status is frozen; blocks all updates while high |
| ev_vld | input | 2 | Per-lane event valid; lane 0 is earlier |
| ev_reg | input | 6 | Per-lane register number, lane i in bits 3i+2:3i |
| ev_delta | input | 10 | Per-lane signed change, lane i in bits 5i+4:5i |
| rec_word | output | 16 | Packed log: first entry in bits 7:0, second in bits 15:8 |

## Verification
Assertions check on every cycle that:
- the fill count never exceeds the number of entries;
- no entry is written by two lanes at once;
- an empty log reads zero;
- a held abort keeps the word stable;
- a clear with no events yields zero;
- a first event is packed exactly as it was presented.

Only the bench scenarios can show the remaining behaviour:
- the event order in realistic sequences, such as an implied pop followed by a destination predecrement;
- the way an overflowing third event or a split two-lane cycle is dropped;
- the frozen value surviving the release of the abort until the next instruction start.

// File: rtl/rmr_pkg.sv
package rmr_pkg;
  localparam int DEF_REG_W   = 3;
  localparam int DEF_DELTA_W = 5;
  localparam int DEF_SLOTS   = 2;
  localparam int DEF_LANES   = 2;
endpackage

// File: rtl/rmr_rst_sync.sv
module rmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rmr_slot_alloc.sv
module rmr_slot_alloc #(
  parameter int LANES = 2,
  parameter int SLOTS = 2,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [LANES-1:0]       lane_vld,
  input  logic [CNT_W-1:0]       fill,
  output logic [SLOTS*LANES-1:0] hit,
  output logic [CNT_W-1:0]       fill_nxt
);
  always_comb begin
    int acc;
    acc = int'(fill);
    hit = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_vld[l]) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (acc == s) hit[s*LANES + l] = 1'b1;
        end
        acc = acc + 1;
      end
    end
    if (acc > SLOTS) acc = SLOTS;
    fill_nxt = CNT_W'(acc);
  end
endmodule

// File: rtl/rmr_entry_reg.sv
module rmr_entry_reg #(
  parameter int ENTRY_W = 8,
  parameter int LANES   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [LANES-1:0]         hit,
  input  logic [LANES*ENTRY_W-1:0] lane_data,
  output logic [ENTRY_W-1:0]       q
);
  logic [ENTRY_W-1:0] d;
  logic               en;

  always_comb begin
    d  = '0;
    en = clr | (|hit);
    for (int l = 0; l < LANES; l++) begin
      if (hit[l]) d = lane_data[l*ENTRY_W +: ENTRY_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/rmr_recorder.sv
module rmr_recorder #(
  parameter int REG_W   = rmr_pkg::DEF_REG_W,
  parameter int DELTA_W = rmr_pkg::DEF_DELTA_W,
  parameter int SLOTS   = rmr_pkg::DEF_SLOTS,
  parameter int LANES   = rmr_pkg::DEF_LANES,
  localparam int ENTRY_W = REG_W + DELTA_W,
  localparam int WORD_W  = SLOTS * ENTRY_W,
  localparam int CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_start,
  input  logic                     abort_held,
  input  logic [LANES-1:0]         ev_vld,
  input  logic [LANES*REG_W-1:0]   ev_reg,
  input  logic [LANES*DELTA_W-1:0] ev_delta,
  output logic [WORD_W-1:0]        rec_word
);
  logic                     rst_sync_n;
  logic                     clr_eff;
  logic [LANES-1:0]         vld_eff;
  logic [CNT_W-1:0]         fill_q, fill_base, fill_nxt, fill_d;
  logic                     fill_en;
  logic [SLOTS*LANES-1:0]   hit;
  logic [LANES*ENTRY_W-1:0] lane_data;

  rmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign clr_eff   = instr_start & ~abort_held;
  assign vld_eff   = ev_vld & {LANES{~abort_held}};
  assign fill_base = clr_eff ? '0 : fill_q;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_pack
      assign lane_data[l*ENTRY_W +: ENTRY_W] =
        {ev_delta[l*DELTA_W +: DELTA_W], ev_reg[l*REG_W +: REG_W]};
    end
  endgenerate

  rmr_slot_alloc #(.LANES(LANES), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_alloc (
    .lane_vld(vld_eff), .fill(fill_base), .hit(hit), .fill_nxt(fill_nxt)
  );

  always_comb begin
    fill_en = clr_eff | (|vld_eff);
    fill_d  = fill_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      rmr_entry_reg #(.ENTRY_W(ENTRY_W), .LANES(LANES)) u_ent (
        .clk(clk), .rst_n(rst_sync_n), .clr(clr_eff),
        .hit(hit[s*LANES +: LANES]), .lane_data(lane_data),
        .q(rec_word[s*ENTRY_W +: ENTRY_W])
      );

      // R4
      slot_single_writer_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        $onehot0(hit[s*LANES +: LANES]));
    end
  endgenerate

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_q <= CNT_W'(SLOTS));

  // R3
  empty_word_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fill_q == '0) |-> (rec_word == '0));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    abort_held |=> $stable(rec_word));

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_start && !abort_held && ev_vld == '0) |=> (rec_word == '0));

  // R2
  entry_pack_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_vld[0] && !abort_held && (instr_start || fill_q == '0))
      |=> (rec_word[ENTRY_W-1:0] ==
           $past({ev_delta[DELTA_W-1:0], ev_reg[REG_W-1:0]})));
endmodule

// File: tb/sim_rmr_recorder.sv
module sim_rmr_recorder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_start;
  logic        abort_held;
  logic [1:0]  ev_vld;
  logic [5:0]  ev_reg;
  logic [9:0]  ev_delta;
  logic [15:0] rec_word;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  rmr_recorder u0 (
    .clk(clk), .rst_n(rst_n), .instr_start(instr_start),
    .abort_held(abort_held), .ev_vld(ev_vld), .ev_reg(ev_reg),
    .ev_delta(ev_delta), .rec_word(rec_word)
  );

  task automatic chk(input string req, input logic [15:0] exp);
    checks++;
    if (rec_word !== exp) begin
      failures++;
      $display("FAIL %s rec_word=%h expected=%h", req, rec_word, exp);
    end
  endtask

  // one cycle of stimulus: inputs set at a falling edge, cleared at the next
  task automatic cyc(input logic st, input logic [1:0] v,
                     input logic [2:0] r0, input logic [4:0] d0,
                     input logic [2:0] r1, input logic [4:0] d1);
    @(negedge clk);
    instr_start = st; ev_vld = v;
    ev_reg = {r1, r0}; ev_delta = {d1, d0};
    @(negedge clk);
    instr_start = 1'b0; ev_vld = 2'b00; ev_reg = '0; ev_delta = '0;
  endtask

  task automatic start_only();
    cyc(1'b1, 2'b00, 3'd0, 5'd0, 3'd0, 5'd0);
  endtask

  task automatic t_reset();
    chk("R1", 16'h0000);
  endtask

  task automatic t_push();
    start_only();
    chk("R6", 16'h0000);
    cyc(1'b0, 2'b01, 3'd6, 5'b11110, 3'd0, 5'd0);
    chk("R2/R3/R9", 16'h00F6);
  endtask

  task automatic t_pop_then_dst();
    start_only();
    cyc(1'b0, 2'b01, 3'd6, 5'b00010, 3'd0, 5'd0);
    chk("R3", 16'h0016);
    cyc(1'b0, 2'b01, 3'd4, 5'b11110, 3'd0, 5'd0);
    chk("R3", 16'hF416);
  endtask

  task automatic t_dual_lane();
    start_only();
    cyc(1'b0, 2'b11, 3'd2, 5'b00010, 3'd6, 5'b00010);
    chk("R4", 16'h1612);
  endtask

  task automatic t_lane1_only();
    start_only();
    cyc(1'b0, 2'b10, 3'd0, 5'd0, 3'd3, 5'b00010);
    chk("R4", 16'h0013);
    cyc(1'b0, 2'b01, 3'd1, 5'b11110, 3'd0, 5'd0);
    chk("R4", 16'hF113);
  endtask

  task automatic t_overflow();
    start_only();
    cyc(1'b0, 2'b01, 3'd2, 5'b00010, 3'd0, 5'd0);
    cyc(1'b0, 2'b01, 3'd3, 5'b00010, 3'd0, 5'd0);
    cyc(1'b0, 2'b01, 3'd4, 5'b11110, 3'd0, 5'd0);
    chk("R5", 16'h1312);
    start_only();
    cyc(1'b0, 2'b01, 3'd2, 5'b00010, 3'd0, 5'd0);
    cyc(1'b0, 2'b11, 3'd5, 5'b00010, 3'd6, 5'b11110);
    chk("R5", 16'h1512);
  endtask

  task automatic t_start_with_event();
    start_only();
    cyc(1'b0, 2'b11, 3'd6, 5'b00010, 3'd4, 5'b11110);
    chk("R6", 16'hF416);
    cyc(1'b1, 2'b01, 3'd6, 5'b11110, 3'd0, 5'd0);
    chk("R6", 16'h00F6);
  endtask

  task automatic t_freeze();
    start_only();
    cyc(1'b0, 2'b01, 3'd4, 5'b11110, 3'd0, 5'd0);
    @(negedge clk); abort_held = 1'b1;
    cyc(1'b0, 2'b01, 3'd6, 5'b11110, 3'd0, 5'd0);
    chk("R7", 16'h00F4);
    start_only();
    chk("R7", 16'h00F4);
    @(negedge clk); abort_held = 1'b0;
    @(negedge clk);
    chk("R8", 16'h00F4);
    start_only();
    chk("R8", 16'h0000);
    cyc(1'b0, 2'b01, 3'd5, 5'b00010, 3'd0, 5'd0);
    chk("R8", 16'h0015);
  endtask

  task automatic t_extremes();
    start_only();
    cyc(1'b0, 2'b01, 3'd7, 5'b01111, 3'd0, 5'd0);
    cyc(1'b0, 2'b01, 3'd0, 5'b10000, 3'd0, 5'd0);
    chk("R2", 16'h807F);
  endtask

  initial begin
    rst_n = 1'b0; instr_start = 1'b0; abort_held = 1'b0;
    ev_vld = '0; ev_reg = '0; ev_delta = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_push();
    t_pop_then_dst();
    t_dual_lane();
    t_lane1_only();
    t_overflow();
    t_start_with_event();
    t_freeze();
    t_extremes();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule